// File: doc/BRIEF.md
# Interrupt Dispatch and Vectoring Unit

This block sits beside a small 8-bit CPU core and decides when the core must stop its normal instruction flow to service a hardware event. It holds a pending-flag register with one bit per event source (vertical blank, LCD status, timer, serial, joypad), an enable register that masks those bits, and a single master interrupt enable. Sources raise single-cycle request pulses that set their pending bit. Software reads and writes both registers through a byte-wide register port, and it turns the master enable on or off with dedicated set and clear strobes.

At the start of every instruction step the core raises `step_i` and presents its current program counter. If the master enable is on and at least one source is both pending and enabled, the unit picks the winning source and then raises `dispatch_valid_o`. It presents the program counter that the core must push, the vector to jump to, and the cycle cost of the dispatch. In the same edge it clears the master enable and the winning pending bit. The core performs the push and the jump and then acknowledges. Stack memory and instruction execution are outside the block. They appear only as the `push_pc_o` and `new_pc_o` outputs.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the pending flags and the enable register are zero, the master enable is off and `dispatch_valid_o` is low.
- R2: A pulse on `req_i[n]` sets pending bit n at the next clock edge. The bit order is 0 vertical blank, 1 LCD status, 2 timer, 3 serial, 4 joypad. A request overrides a register write or a dispatch clear of the same bit in the same cycle.
- R3: Address 0xFF0F reads the pending flags in bits 4:0, with bits 7:5 reading as 1. A write there loads bits 4:0. Address 0xFFFF is an 8-bit enable register that can be read and written, and its bits 4:0 mask the sources. Any other address reads 0x00 and ignores writes.
- R4: A dispatch starts one edge after a cycle with `step_i` high, the master enable on, a nonzero `pending & enable`, and no dispatch outstanding. In all other cases no dispatch starts.
- R5: When several sources are eligible, the lowest-numbered bit wins.
- R6: The vector for source n is 0x40 + 8*n: 0x40, 0x48, 0x50, 0x58 or 0x60.
- R7: A dispatch clears the master enable and only the winning pending bit. A dispatch or `ime_clr_i` takes priority over `ime_set_i` in the same cycle.
- R8: During a dispatch, `push_pc_o` holds the `pc_i` sampled at the step and `cost_o` reads 20. The outputs stay stable while `dispatch_valid_o` is high, until the cycle with `dispatch_ack_i` high. `dispatch_valid_o` falls at the following edge.
- R9: A request pulse that arrives in the same cycle as the dispatch clear of a different bit is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Per-source request pulses |
| reg_addr_i | input | 16 | Register port address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ime_set_i | input | 1 | Turn the master enable on |
| ime_clr_i | input | 1 | Turn the master enable off |
| step_i | input | 1 | Start of an instruction step |
| pc_i | input | 16 | Core program counter at the step |
| dispatch_ack_i | input | 1 | Core has finished the push and the jump |
| dispatch_valid_o | output | 1 | Dispatch outstanding |
| push_pc_o | output | 16 | Program counter the core must push |
| new_pc_o | output | 16 | Vector address to jump to |
| cost_o | output | 5 | Dispatch cost in clock cycles |

## Verification
The bound checker checks the following on every cycle. A dispatch always leaves the master enable off. No dispatch begins without a step or while the master enable is off. The outputs hold until the acknowledge, and the valid signal falls right after it. Every vector is an aligned slot inside the five-entry table. The bench scenarios cover what depends on data history. These are the priority order between several pending sources, masking by the enable register, the exact pending bits left after a dispatch, and a request that collides with a write or with a dispatch clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC         = 5;
  localparam int unsigned ADDR_W          = 16;
  localparam int unsigned DATA_W          = 8;
  localparam int unsigned VEC_BASE        = 'h40;
  localparam int unsigned VEC_STRIDE      = 8;
  localparam int unsigned DISPATCH_CYCLES = 20;
  localparam int unsigned FLAG_ADDR       = 'hFF0F;
  localparam int unsigned EN_ADDR         = 'hFFFF;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  // per-bit priority: request > dispatch clear > software write > hold
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= 1'b0;
      else if (req_i[b])   q <= 1'b1;
      else if (clr_i[b])   q <= 1'b0;
      else if (wr_en_i)    q <= wdata_i[b];
    end
    assign flag_o[b] = q;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 5,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  // lowest set bit wins
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o    = IDX_W'(i);
        onehot_o = N'(1) << i;
      end
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl #(
  parameter int unsigned N          = 5,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 'h40,
  parameter int unsigned VEC_STRIDE = 8,
  parameter int unsigned COST       = 20,
  localparam int unsigned IDX_W     = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned COST_W    = $clog2(COST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [N-1:0]      onehot_i,
  input  logic              ime_set_i,
  input  logic              ime_clr_i,
  input  logic              ack_i,
  output logic              ime_o,
  output logic [N-1:0]      clr_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] push_pc_o,
  output logic [ADDR_W-1:0] new_pc_o,
  output logic [COST_W-1:0] cost_o
);
  logic              fire;
  logic              ime_q;
  logic              valid_q;
  logic [ADDR_W-1:0] push_q;
  logic [ADDR_W-1:0] vec_q;
  logic [ADDR_W-1:0] vec_d;

  assign fire  = step_i && ime_q && any_i && !valid_q;
  assign clr_o = fire ? onehot_i : '0;
  assign vec_d = ADDR_W'(VEC_BASE + 32'(idx_i) * VEC_STRIDE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ime_q <= 1'b0;
    else if (fire || ime_clr_i)   ime_q <= 1'b0;
    else if (ime_set_i)           ime_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      push_q  <= '0;
      vec_q   <= '0;
    end else if (fire) begin
      valid_q <= 1'b1;
      push_q  <= pc_i;
      vec_q   <= vec_d;
    end else if (valid_q && ack_i) begin
      valid_q <= 1'b0;
    end
  end

  assign ime_o     = ime_q;
  assign valid_o   = valid_q;
  assign push_pc_o = push_q;
  assign new_pc_o  = vec_q;
  assign cost_o    = valid_q ? COST_W'(COST) : '0;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter int unsigned N          = NUM_SRC,
  parameter int unsigned AW         = ADDR_W,
  parameter int unsigned DW         = DATA_W,
  parameter int unsigned VBASE      = VEC_BASE,
  parameter int unsigned VSTRIDE    = VEC_STRIDE,
  parameter int unsigned COST       = DISPATCH_CYCLES,
  parameter int unsigned F_ADDR     = FLAG_ADDR,
  parameter int unsigned E_ADDR     = EN_ADDR,
  localparam int unsigned IDX_W     = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned COST_W    = $clog2(COST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              ime_set_i,
  input  logic              ime_clr_i,
  input  logic              step_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              dispatch_ack_i,
  output logic              dispatch_valid_o,
  output logic [AW-1:0]     push_pc_o,
  output logic [AW-1:0]     new_pc_o,
  output logic [COST_W-1:0] cost_o
);
  reg_sel_e         sel;
  logic [N-1:0]     flag_w;
  logic [N-1:0]     clr_w;
  logic [N-1:0]     onehot_w;
  logic [DW-1:0]    en_q;
  logic [N-1:0]     elig_w;
  logic             any_w;
  logic [IDX_W-1:0] idx_w;
  logic             ime_w;

  always_comb begin
    if (reg_addr_i == AW'(F_ADDR))      sel = SEL_FLAG;
    else if (reg_addr_i == AW'(E_ADDR)) sel = SEL_EN;
    else                                sel = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         en_q <= '0;
    else if (reg_wr_i && sel == SEL_EN)  en_q <= reg_wdata_i;
  end

  irq_flag_reg #(.N(N)) u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .wr_en_i (reg_wr_i && sel == SEL_FLAG),
    .wdata_i (reg_wdata_i[N-1:0]),
    .clr_i   (clr_w),
    .flag_o  (flag_w)
  );

  assign elig_w = flag_w & en_q[N-1:0];

  irq_prio_enc #(.N(N)) u_prio (
    .pend_i   (elig_w),
    .any_o    (any_w),
    .idx_o    (idx_w),
    .onehot_o (onehot_w)
  );

  irq_dispatch_ctrl #(
    .N(N), .ADDR_W(AW), .VEC_BASE(VBASE), .VEC_STRIDE(VSTRIDE), .COST(COST)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .pc_i      (pc_i),
    .any_i     (any_w),
    .idx_i     (idx_w),
    .onehot_i  (onehot_w),
    .ime_set_i (ime_set_i),
    .ime_clr_i (ime_clr_i),
    .ack_i     (dispatch_ack_i),
    .ime_o     (ime_w),
    .clr_o     (clr_w),
    .valid_o   (dispatch_valid_o),
    .push_pc_o (push_pc_o),
    .new_pc_o  (new_pc_o),
    .cost_o    (cost_o)
  );

  // unused flag bits read back as ones
  always_comb begin
    unique case (sel)
      SEL_FLAG: reg_rdata_o = {{(DW-N){1'b1}}, flag_w};
      SEL_EN:   reg_rdata_o = en_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int unsigned N       = 5,
  parameter int unsigned AW      = 16,
  parameter int unsigned VBASE   = 'h40,
  parameter int unsigned VSTRIDE = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ime_i,
  input logic          step_i,
  input logic          valid_i,
  input logic          ack_i,
  input logic [AW-1:0] new_pc_i
);
  localparam int unsigned VLAST = VBASE + VSTRIDE * (N - 1);

  AST_IME_OFF_AFTER_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> !ime_i); // R7
  AST_NO_DISPATCH_IME_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ime_i && !valid_i) |=> !valid_i); // R4
  AST_NO_DISPATCH_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !valid_i) |=> !valid_i); // R4
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ack_i) |=> (valid_i && $stable(new_pc_i))); // R8
  AST_DROP_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ack_i) |=> !valid_i); // R8
  AST_VECTOR_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (32'(new_pc_i) >= VBASE && 32'(new_pc_i) <= VLAST
                 && (32'(new_pc_i) - VBASE) % VSTRIDE == 0)); // R6
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .N(N), .AW(AW), .VBASE(VBASE), .VSTRIDE(VSTRIDE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ime_i    (ime_w),
  .step_i   (step_i),
  .valid_i  (dispatch_valid_o),
  .ack_i    (dispatch_ack_i),
  .new_pc_i (new_pc_o)
);

// File: tb/tb_irq_dispatch.sv
`timescale 1ns/1ps
module tb_irq_dispatch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  req_i = '0;
  logic [15:0] reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        ime_set_i = 1'b0;
  logic        ime_clr_i = 1'b0;
  logic        step_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic        dispatch_ack_i = 1'b0;
  logic        dispatch_valid_o;
  logic [15:0] push_pc_o;
  logic [15:0] new_pc_o;
  logic [4:0]  cost_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_dispatch dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    cyc();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [15:0] a, logic [7:0] exp);
    reg_addr_i = a; #1;
    check(req, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic pulse(logic [4:0] m);
    req_i = m; cyc(); req_i = '0;
  endtask

  task automatic ime_on();
    ime_set_i = 1'b1; cyc(); ime_set_i = 1'b0;
  endtask

  task automatic step(logic [15:0] pc);
    step_i = 1'b1; pc_i = pc; cyc(); step_i = 1'b0;
  endtask

  task automatic ack();
    dispatch_ack_i = 1'b1; cyc(); dispatch_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(dispatch_valid_o), 0);
    rd_chk("R1 flag", 16'hFF0F, 8'hE0);
    rd_chk("R1 enable", 16'hFFFF, 8'h00);
    rd_chk("R3 other addr", 16'h1234, 8'h00);
  endtask

  task automatic t_regs();
    wr(16'hFF0F, 8'h15);
    rd_chk("R3 flag write", 16'hFF0F, 8'hF5);
    wr(16'h0040, 8'hFF);
    rd_chk("R3 ignored write", 16'hFF0F, 8'hF5);
    rd_chk("R3 ignored write en", 16'hFFFF, 8'h00);
    // request wins over a same-cycle write of zero
    reg_addr_i = 16'hFF0F; reg_wdata_i = 8'h00; reg_wr_i = 1'b1; req_i = 5'h02;
    cyc();
    reg_wr_i = 1'b0; req_i = '0;
    rd_chk("R2 req over write", 16'hFF0F, 8'hE2);
    wr(16'hFF0F, 8'h00);
    wr(16'hFFFF, 8'hFF);
    rd_chk("R3 enable 8 bit", 16'hFFFF, 8'hFF);
    wr(16'hFFFF, 8'h1F);
  endtask

  task automatic t_ime_off();
    pulse(5'h01);
    rd_chk("R2 vblank latch", 16'hFF0F, 8'hE1);
    step(16'h0100);
    check("R4 no dispatch ime off", 32'(dispatch_valid_o), 0);
    rd_chk("R4 flag kept", 16'hFF0F, 8'hE1);
    wr(16'hFF0F, 8'h00);
  endtask

  task automatic t_single();
    pulse(5'h04);
    ime_on();
    step(16'h1234);
    check("R4 dispatch", 32'(dispatch_valid_o), 1);
    check("R6 timer vector", 32'(new_pc_o), 32'h50);
    check("R8 push pc", 32'(push_pc_o), 32'h1234);
    check("R8 cost", 32'(cost_o), 20);
    rd_chk("R7 bit cleared", 16'hFF0F, 8'hE0);
    cyc(); cyc();
    check("R8 held", 32'(dispatch_valid_o), 1);
    check("R8 held vec", 32'(new_pc_o), 32'h50);
    ack();
    check("R8 drop after ack", 32'(dispatch_valid_o), 0);
    pulse(5'h04);
    step(16'h2000);
    check("R7 ime cleared", 32'(dispatch_valid_o), 0);
    wr(16'hFF0F, 8'h00);
  endtask

  task automatic t_priority();
    logic [15:0] exp_v;
    pulse(5'h1F);
    for (int i = 0; i < 5; i++) begin
      ime_on();
      step(16'h0300 + 16'(i));
      exp_v = 16'h40 + 16'(8 * i);
      check("R5 priority order", 32'(new_pc_o), 32'(exp_v));
      rd_chk("R7 only winner cleared", 16'hFF0F, 8'hE0 | 8'((5'h1F << (i + 1)) & 5'h1F));
      ack();
    end
  endtask

  task automatic t_mask();
    wr(16'hFFFF, 8'h08);
    pulse(5'h0D);
    ime_on();
    step(16'h0400);
    check("R5 masked skip", 32'(new_pc_o), 32'h58);
    rd_chk("R7 masked kept", 16'hFF0F, 8'hE5);
    ack();
    ime_on();
    step(16'h0401);
    check("R4 none enabled", 32'(dispatch_valid_o), 0);
    wr(16'hFF0F, 8'h00);
    wr(16'hFFFF, 8'h1F);
  endtask

  task automatic t_collide();
    pulse(5'h01);
    ime_on();
    req_i = 5'h08; step(16'h0500); req_i = '0;
    check("R9 dispatch vblank", 32'(new_pc_o), 32'h40);
    rd_chk("R9 serial latched", 16'hFF0F, 8'hE8);
    // while outstanding a second step is ignored
    ime_on();
    step(16'h0600);
    check("R8 outstanding push", 32'(push_pc_o), 32'h0500);
    ack();
    step(16'h0700);
    check("R4 next dispatch", 32'(new_pc_o), 32'h58);
    ack();
    // clear beats set
    ime_set_i = 1'b1; ime_clr_i = 1'b1; cyc(); ime_set_i = 1'b0; ime_clr_i = 1'b0;
    pulse(5'h10);
    step(16'h0800);
    check("R7 clear over set", 32'(dispatch_valid_o), 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_ime_off();
    t_single();
    t_priority();
    t_mask();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule